// File: doc/BRIEF.md
# Error Pin Mode and Status Controller

This block manages a small set of active-low, open-drain error pins. Every pin has a two-bit mode field in a control register. In error-signaling mode the pin's pull-down follows an internal error source, and a sticky status bit records each new assertion of the pin. In general-purpose output mode a software-written data bit decides whether the pull-down is on. The remaining two mode codes switch the pin off. The block only ever enables or releases a pull-down. The pad's high level comes from an external pull-up.

Software reaches three 32-bit registers through a plain write-enable/address/data port. The read data follows the address combinationally. Status bits are cleared by writing 1 to them. They survive the ordinary soft reset and are cleared only by a separate power-good reset.

Top module: `errpin_ctrl`

## Requirements
- R1: After reset the control (offset 0x0), data (offset 0x4) and status (offset 0x8) registers read 0, and no pull-down is enabled.
- R2: With a pin's mode field (control bits [2i+1:2i]) at 01b, the pull-down is on when the pin's data bit (data bit i) is 0 and off when it is 1.
- R3: With mode 10b, the pin's pull-down is on exactly while its error input is high, in the same cycle.
- R4: With mode 00b or 11b, the pull-down is off whatever the error input and the data bit are.
- R5: In mode 10b, status bit i is set at the first clock edge after the pin goes from released to pulled down. If the bit is cleared while the pin stays asserted, it is not set again.
- R6: Status bits are never set by hardware in modes other than 10b, including on pin assertions in output mode.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: If a hardware set and a write-1 clear of the same status bit fall in the same cycle, the bit ends up set.
- R9: Status bits keep their value through the soft reset (`rst_n`), which does clear control and data. Only the power-good reset (`pwrgood_n`) clears status bits.
- R10: A data bit reads back its stored value only while its pin is in mode 01b, and reads 0 otherwise. Control bits above 2*NPINS-1 and data or status bits above NPINS-1 read 0.
- R11: Offsets other than 0x0, 0x4 and 0x8 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low soft reset for the control, data and edge-history state |
| pwrgood_n | input | 1 | Active-low power-good reset, the only reset for the status bits |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current offset (combinational) |
| err_src_i | input | NPINS | Internal error sources, one per pin, active high |
| pad_pulldown_o | output | NPINS | Pull-down enable per open-drain pad; 1 pulls the pin low |

## Verification
A table sweeps uniform and mixed mode settings against data and error patterns. Setting the data bits and error inputs to opposite values shows which of the two sources a pin follows, and driving every input active shows that the off modes really gate the pin. The directed tests drive single-pin assertion edges and hold them, so a level-sensitive set can be told apart from an edge-sensitive one. A write-1 clear and a set are made to coincide, and status is checked through each reset in turn to separate the sticky domain from the soft one.

// File: rtl/errpin_pkg.sv
package errpin_pkg;

    // Register data width and offset decoding width
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_DATA = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;

    // Two-bit per-pin usage code
    typedef enum logic [1:0] {
        PM_OFF  = 2'b00,
        PM_GPO  = 2'b01,
        PM_ERR  = 2'b10,
        PM_OFF2 = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/errpin_lane.sv
// One pin: output selection, assertion-edge detection, data read masking.
module errpin_lane
    import errpin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       data_i,
    input  logic       err_i,
    output logic       pulldown_o,
    output logic       set_o,
    output logic       data_rd_o
);

    typedef struct packed {
        logic prev;   // pin asserted in the previous cycle
    } lane_st_t;

    lane_st_t st_d, st_q;
    pin_mode_e mode;

    always_comb begin
        mode       = pin_mode_e'(mode_i);
        pulldown_o = 1'b0;
        unique case (mode)
            PM_GPO:  pulldown_o = ~data_i;
            PM_ERR:  pulldown_o = err_i;
            default: pulldown_o = 1'b0;
        endcase
        set_o     = (mode == PM_ERR) && pulldown_o && !st_q.prev;
        data_rd_o = (mode == PM_GPO) && data_i;
        st_d.prev = pulldown_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A set pulse marks a single edge; it cannot repeat on the next cycle.
    assert_single_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |=> !set_o)
        else $error("set pulse repeated");

endmodule

// File: rtl/errpin_status.sv
// Sticky status bits in the power-good reset domain.
module errpin_status #(
    parameter int NPINS = 3
) (
    input  logic             clk,
    input  logic             pwrgood_n,
    input  logic [NPINS-1:0] set_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] stat_o
);

    typedef struct packed {
        logic [NPINS-1:0] stat;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        // set has priority over clear
        st_d.stat = (st_q.stat & ~clr_i) | set_i;
        stat_o    = st_q.stat;
    end

    always_ff @(posedge clk or negedge pwrgood_n) begin
        if (!pwrgood_n) st_q <= '0;
        else            st_q <= st_d;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!pwrgood_n)
            (st_q.stat[g] && !clr_i[g]) |=> st_q.stat[g])
            else $error("status bit lost without clear");

        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!pwrgood_n)
            set_i[g] |=> st_q.stat[g])
            else $error("set event lost");
    end

endmodule

// File: rtl/errpin_ctrl.sv
// Register-mapped controller for open-drain error pins.
module errpin_ctrl
    import errpin_pkg::*;
#(
    parameter int NPINS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrgood_n,
    input  logic             reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NPINS-1:0] err_src_i,
    output logic [NPINS-1:0] pad_pulldown_o
);

    localparam int CTRL_W = 2 * NPINS;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [NPINS-1:0]  data;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] stat_vec;
    logic [NPINS-1:0] data_rd;
    logic             addr_known;

    // Next-state and read path
    always_comb begin
        cfg_d      = cfg_q;
        clr_vec    = '0;
        addr_known = (reg_addr == OFS_CTRL) || (reg_addr == OFS_DATA) ||
                     (reg_addr == OFS_STAT);
        if (reg_wr_en) begin
            unique case (reg_addr)
                OFS_CTRL: cfg_d.ctrl = reg_wdata[CTRL_W-1:0];
                OFS_DATA: cfg_d.data = reg_wdata[NPINS-1:0];
                OFS_STAT: clr_vec    = reg_wdata[NPINS-1:0];
                default:  ;
            endcase
        end
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = REG_W'(cfg_q.ctrl);
            OFS_DATA: reg_rdata = REG_W'(data_rd);
            OFS_STAT: reg_rdata = REG_W'(stat_vec);
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_lane
        errpin_lane i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (cfg_q.ctrl[2*g+1:2*g]),
            .data_i     (cfg_q.data[g]),
            .err_i      (err_src_i[g]),
            .pulldown_o (pad_pulldown_o[g]),
            .set_o      (set_vec[g]),
            .data_rd_o  (data_rd[g])
        );

        assert_off_modes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_q.ctrl[2*g+1:2*g] == PM_OFF) || (cfg_q.ctrl[2*g+1:2*g] == PM_OFF2))
            |-> !pad_pulldown_o[g])
            else $error("pull-down active in off mode");

        assert_set_err_mode_R6: assert property (@(posedge clk)
            disable iff (!rst_n || !pwrgood_n)
            $rose(stat_vec[g]) |-> $past(cfg_q.ctrl[2*g+1:2*g] == PM_ERR))
            else $error("status set outside error mode");
    end

    errpin_status #(.NPINS(NPINS)) i_status (
        .clk       (clk),
        .pwrgood_n (pwrgood_n),
        .set_i     (set_vec),
        .clr_i     (clr_vec),
        .stat_o    (stat_vec)
    );

    assert_unknown_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !addr_known) |=> $stable(cfg_q))
        else $error("write to unknown offset changed state");

endmodule

// File: tb/test_errpin_ctrl.sv
`timescale 1ns/1ps
module test_errpin_ctrl;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_DATA = 4'h4;
    localparam logic [3:0] A_STAT = 4'h8;
    localparam logic [3:0] A_NONE = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrgood_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  err_src = 3'b111;
    logic [2:0]  pd;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    errpin_ctrl #(.NPINS(3)) i_errpin_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwrgood_n      (pwrgood_n),
        .reg_wr_en      (reg_wr_en),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .err_src_i      (err_src),
        .pad_pulldown_o (pd)
    );

    typedef struct packed {
        logic [5:0] ctrl;
        logic [2:0] data;
        logic [2:0] err;
        logic [2:0] exp_pd;
        logic [2:0] exp_rd;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{6'b000000, 3'b000, 3'b111, 3'b000, 3'b000},
        '{6'b010101, 3'b000, 3'b000, 3'b111, 3'b000},
        '{6'b010101, 3'b101, 3'b111, 3'b010, 3'b101},
        '{6'b010101, 3'b111, 3'b111, 3'b000, 3'b111},
        '{6'b101010, 3'b000, 3'b101, 3'b101, 3'b000},
        '{6'b101010, 3'b000, 3'b010, 3'b010, 3'b000},
        '{6'b111111, 3'b000, 3'b111, 3'b000, 3'b000},
        '{6'b100111, 3'b000, 3'b111, 3'b110, 3'b000},
        '{6'b011001, 3'b100, 3'b010, 3'b011, 3'b100},
        '{6'b001110, 3'b000, 3'b111, 3'b001, 3'b000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pg_reset();
        @(negedge clk);
        pwrgood_n = 1'b0;
        @(negedge clk);
        pwrgood_n = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pwrgood_n = 1'b1;

        // R1: reset state
        reg_read(A_CTRL, rv); check("R1 ctrl", rv, 32'h0);
        reg_read(A_DATA, rv); check("R1 data", rv, 32'h0);
        reg_read(A_STAT, rv); check("R1 stat", rv, 32'h0);
        check("R1 pulldown", {29'h0, pd}, 32'h0);

        // R2 R3 R4 R10: table walk
        for (int i = 0; i < NVEC; i++) begin
            reg_write(A_CTRL, {26'h0, VECS[i].ctrl});
            reg_write(A_DATA, {29'h0, VECS[i].data});
            err_src = VECS[i].err;
            #1;
            check($sformatf("R2/R3/R4 vec%0d pulldown", i), {29'h0, pd}, {29'h0, VECS[i].exp_pd});
            reg_read(A_DATA, rv);
            check($sformatf("R10 vec%0d data read", i), rv, {29'h0, VECS[i].exp_rd});
        end

        // Fresh status, all pins in error mode, sources low
        err_src = 3'b000;
        pg_reset();
        reg_write(A_CTRL, 32'h2A);
        reg_read(A_STAT, rv); check("R9 stat after power-good", rv, 32'h0);

        // R5: edge set, no re-set while held
        @(negedge clk); err_src[0] = 1'b1;
        reg_read(A_STAT, rv); check("R5 stat before edge", rv, 32'h0);
        @(negedge clk);
        reg_read(A_STAT, rv); check("R5 stat after edge", rv, 32'h1);
        reg_write(A_STAT, 32'h1);
        repeat (2) @(negedge clk);
        reg_read(A_STAT, rv); check("R5 held pin no re-set", rv, 32'h0);

        // R7: write-1-clear, write-0 no effect
        @(negedge clk); err_src[1] = 1'b1;
        @(negedge clk);
        reg_read(A_STAT, rv); check("R7 pin1 set", rv, 32'h2);
        reg_write(A_STAT, 32'h0);
        reg_read(A_STAT, rv); check("R7 write zero", rv, 32'h2);
        reg_write(A_STAT, 32'h5);
        reg_read(A_STAT, rv); check("R7 write other bits", rv, 32'h2);
        reg_write(A_STAT, 32'h2);
        reg_read(A_STAT, rv); check("R7 write one clears", rv, 32'h0);

        // R8: set and clear in the same cycle
        @(negedge clk);
        err_src[2] = 1'b1;
        reg_wr_en  = 1'b1;
        reg_addr   = A_STAT;
        reg_wdata  = 32'h4;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_read(A_STAT, rv); check("R8 set beats clear", rv, 32'h4);
        reg_write(A_STAT, 32'h7);

        // R6: no hardware set outside error mode
        err_src = 3'b000;
        reg_write(A_CTRL, 32'h15);
        reg_write(A_DATA, 32'h7);
        reg_write(A_DATA, 32'h0);
        @(negedge clk);
        reg_read(A_STAT, rv); check("R6 output mode edges", rv, 32'h0);
        reg_write(A_CTRL, 32'h0);
        @(negedge clk); err_src = 3'b111;
        @(negedge clk); err_src = 3'b000;
        reg_write(A_CTRL, 32'h3F);
        @(negedge clk); err_src = 3'b111;
        @(negedge clk);
        reg_read(A_STAT, rv); check("R6 off mode edges", rv, 32'h0);

        // R9: status survives soft reset, cleared by power-good
        err_src = 3'b000;
        reg_write(A_CTRL, 32'h2A);
        @(negedge clk); err_src[1] = 1'b1;
        @(negedge clk);
        reg_read(A_STAT, rv); check("R9 stat set", rv, 32'h2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_read(A_STAT, rv); check("R9 stat through soft reset", rv, 32'h2);
        reg_read(A_CTRL, rv); check("R9 ctrl cleared by soft reset", rv, 32'h0);
        check("R9 pulldown after soft reset", {29'h0, pd}, 32'h0);
        pg_reset();
        reg_read(A_STAT, rv); check("R9 stat cleared by power-good", rv, 32'h0);

        // R10: unused bits read zero
        reg_write(A_CTRL, 32'hFFFF_FFFF);
        reg_read(A_CTRL, rv); check("R10 ctrl upper bits", rv, 32'h3F);
        reg_write(A_CTRL, 32'h15);
        reg_write(A_DATA, 32'hFFFF_FFFF);
        reg_read(A_DATA, rv); check("R10 data upper bits", rv, 32'h7);

        // R11: unknown offset
        reg_write(A_NONE, 32'hFFFF_FFFF);
        reg_read(A_NONE, rv); check("R11 unknown read", rv, 32'h0);
        reg_read(A_CTRL, rv); check("R11 ctrl untouched", rv, 32'h15);
        reg_read(A_DATA, rv); check("R11 data untouched", rv, 32'h7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule